// File: doc/BRIEF.md
# Prescaled Second-Order Audio Filter with Bass Mix

This block runs one second-order recursive filter on a stream of signed audio samples, one sample each time a valid strobe is raised (at a 48 kHz audio rate this is rare compared with the clock). It uses direct form I. Every sample updates two input history registers and two output history registers.

Fractional arithmetic can only hold coefficient values below one in magnitude, and filters used for equalization often need larger values. So the five coefficients are supplied already divided by 2^S, where S is a build-time shift chosen so that every coefficient fits a signed fraction in [-1, 1). The accumulated result is shifted left by S and saturated to the sample width. That restored value is the filter output, and it is also what is written into the feedback history.

The filter runs on the left channel. Its output is multiplied by a shared gain and added to both the left and right wideband samples, which gives a bass-boost mix for the two channels. The coefficient and gain inputs are treated as static while samples flow.

Top module: `bass_biquad`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and left_o, right_o and filt_o are 0. After reset the history holds zero, so the first output depends only on the first input.
- R2: valid_o is high in exactly the cycle after a cycle in which valid_i was high at a rising clock edge.
- R3: For each accepted sample x, filt_o = floor(2^S · (c0·x + c1·x1 + c2·x2 − c3·y1 − c4·y2)), saturated to W bits.
  - The terms are:
    - x1 and x2 are the two previous accepted inputs.
    - y1 and y2 are the two previous filt_o values.
    - ck is the signed CW-bit field k of coef_i, at bits [k·CW +: CW], read as a fraction with CW−1 fractional bits.
  - The field order, from least significant upward, is: forward taps 0, 1, 2, then feedback taps 1, 2.
- R4: An effective coefficient of magnitude above one is realised. With S=1, a field 0 value of 24576 (0.75) acts as a gain of 1.5 on the current input.
- R5: The feedback history stores the restored value, not the prescaled one. An impulse of 1000 through field 0 = 16384 and field 3 = −8192 (all other fields 0) gives 1000, 500, 250.
- R6: When the restored result leaves the W-bit range, filt_o saturates to 2^(W−1)−1 or −2^(W−1), and that saturated value is what enters the feedback history.
- R7: A cycle with valid_i low changes neither the outputs nor the history. The next accepted sample continues the recursion as if no idle cycles had occurred.
- R8: left_o = sat(left_i + floor(filt · gain_i / 2^GF)). Here filt is the filter result for the same sample, gain_i is a signed value with GF fractional bits, and sat clamps to W bits.
- R9: right_o = sat(right_i + floor(filt · gain_i / 2^GF)). It uses the left-channel filter result, so one gain term is shared by both channels.
- R10: If the mix sum leaves the W-bit range, left_o or right_o clamps to the largest or smallest W-bit value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample strobe; accepts left_i/right_i this cycle |
| left_i | input | W | Left wideband sample, filter input |
| right_i | input | W | Right wideband sample |
| coef_i | input | 5·CW | Prescaled coefficients, field order as in R3 |
| gain_i | input | GW | Signed bass gain, GF fractional bits |
| valid_o | output | 1 | Output sample strobe |
| left_o | output | W | Left channel with bass added |
| right_o | output | W | Right channel with bass added |
| filt_o | output | W | Restored filter output |

## Verification
A corrupted history register does not stay hidden. It shows up in filt_o on the next accepted sample, and because of the feedback it keeps appearing in every later sample until it decays at the pole radius. A missing restore shift or a wrong field order breaks the 1000/500/250 impulse pattern within three samples. Comparing against a floating-point model at every sample, with idle gaps in between, exposes state that drifts during idle cycles. The exact bass-mix check built from filt_o isolates errors in the gain path from errors in the filter path.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int NTAP = 5;
  typedef enum int {TAP_B0 = 0, TAP_B1 = 1, TAP_B2 = 2, TAP_A1 = 3, TAP_A2 = 4} tap_e;
endpackage

// File: rtl/biquad_mac.sv
module biquad_mac
  import biquad_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 16,
  parameter int AW = W + CW + 3
) (
  input  logic signed [W-1:0]       x0_i,
  input  logic signed [W-1:0]       x1_i,
  input  logic signed [W-1:0]       x2_i,
  input  logic signed [W-1:0]       y1_i,
  input  logic signed [W-1:0]       y2_i,
  input  logic [NTAP*CW-1:0]        coef_i,
  output logic signed [AW-1:0]      acc_o
);
  localparam int PW = W + CW;

  logic signed [W-1:0]  samp [NTAP];
  logic signed [CW-1:0] cf   [NTAP];
  logic signed [PW-1:0] prod [NTAP];

  assign samp[TAP_B0] = x0_i;
  assign samp[TAP_B1] = x1_i;
  assign samp[TAP_B2] = x2_i;
  assign samp[TAP_A1] = y1_i;
  assign samp[TAP_A2] = y2_i;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign cf[i]   = $signed(coef_i[i*CW +: CW]);
    assign prod[i] = samp[i] * cf[i];
  end

  // full-width sum: feedback taps subtracted
  always_comb begin
    acc_o = '0;
    for (int i = 0; i < NTAP; i++) begin
      if (i >= int'(TAP_A1))
        acc_o = acc_o - {{(AW-PW){prod[i][PW-1]}}, prod[i]};
      else
        acc_o = acc_o + {{(AW-PW){prod[i][PW-1]}}, prod[i]};
    end
  end
endmodule

// File: rtl/biquad_restore.sv
module biquad_restore #(
  parameter int AW = 35,
  parameter int W  = 16,
  parameter int CW = 16,
  parameter int S  = 1
) (
  input  logic signed [AW-1:0] acc_i,
  output logic signed [W-1:0]  y_o
);
  // drop fractional bits, minus S for the prescale restore
  localparam int SH = CW - 1 - S;
  localparam logic signed [AW-1:0] MAXV = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [AW-1:0] shifted;

  assign shifted = acc_i >>> SH;

  always_comb begin
    if (shifted > MAXV)      y_o = MAXV[W-1:0];
    else if (shifted < MINV) y_o = MINV[W-1:0];
    else                     y_o = shifted[W-1:0];
  end
endmodule

// File: rtl/bass_mix.sv
module bass_mix #(
  parameter int W  = 16,
  parameter int GW = 16,
  parameter int GF = 12,
  parameter int NCH = 2
) (
  input  logic signed [W-1:0]  filt_i,
  input  logic signed [GW-1:0] gain_i,
  input  logic signed [W-1:0]  chan_i [NCH],
  output logic signed [W-1:0]  chan_o [NCH]
);
  localparam int PW = W + GW;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] MAXV = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] boost;

  assign prod  = filt_i * gain_i;
  assign boost = prod >>> GF;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [SW-1:0] sum;
    assign sum = {{(SW-W){chan_i[c][W-1]}}, chan_i[c]} + {boost[PW-1], boost};
    always_comb begin
      if (sum > MAXV)      chan_o[c] = MAXV[W-1:0];
      else if (sum < MINV) chan_o[c] = MINV[W-1:0];
      else                 chan_o[c] = sum[W-1:0];
    end
  end
endmodule

// File: rtl/bass_biquad.sv
module bass_biquad
  import biquad_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 16,
  parameter int S  = 1,
  parameter int GW = 16,
  parameter int GF = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [W-1:0]         left_i,
  input  logic [W-1:0]         right_i,
  input  logic [NTAP*CW-1:0]   coef_i,
  input  logic [GW-1:0]        gain_i,
  output logic                 valid_o,
  output logic [W-1:0]         left_o,
  output logic [W-1:0]         right_o,
  output logic [W-1:0]         filt_o
);
  localparam int AW = W + CW + 3;

  logic signed [W-1:0]  x1_q, x2_q, y1_q, y2_q;
  logic signed [AW-1:0] acc;
  logic signed [W-1:0]  y_new;
  logic signed [W-1:0]  ch_in  [2];
  logic signed [W-1:0]  ch_out [2];

  biquad_mac #(.W(W), .CW(CW), .AW(AW)) u_mac (
    .x0_i   ($signed(left_i)),
    .x1_i   (x1_q),
    .x2_i   (x2_q),
    .y1_i   (y1_q),
    .y2_i   (y2_q),
    .coef_i (coef_i),
    .acc_o  (acc)
  );

  biquad_restore #(.AW(AW), .W(W), .CW(CW), .S(S)) u_restore (
    .acc_i (acc),
    .y_o   (y_new)
  );

  assign ch_in[0] = $signed(left_i);
  assign ch_in[1] = $signed(right_i);

  bass_mix #(.W(W), .GW(GW), .GF(GF), .NCH(2)) u_mix (
    .filt_i (y_new),
    .gain_i ($signed(gain_i)),
    .chan_i (ch_in),
    .chan_o (ch_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q    <= '0;
      x2_q    <= '0;
      y1_q    <= '0;
      y2_q    <= '0;
      valid_o <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      filt_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        x2_q    <= x1_q;
        x1_q    <= $signed(left_i);
        y2_q    <= y1_q;
        y1_q    <= y_new;  // restored value feeds back
        filt_o  <= y_new;
        left_o  <= ch_out[0];
        right_o <= ch_out[1];
      end
    end
  end
endmodule

// File: rtl/bass_biquad_chk.sv
module bass_biquad_chk #(
  parameter int W  = 16,
  parameter int GW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [W-1:0]  left_i,
  input logic [W-1:0]  right_i,
  input logic [GW-1:0] gain_i,
  input logic          valid_o,
  input logic [W-1:0]  left_o,
  input logic [W-1:0]  right_o,
  input logic [W-1:0]  filt_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && left_o == '0 && right_o == '0 && filt_o == '0)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2

  AST_VALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(filt_o) && $stable(left_o) && $stable(right_o))); // R7

  AST_ZERO_GAIN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && gain_i == '0) |=> (left_o == $past(left_i) && right_o == $past(right_i))); // R8
endmodule

bind bass_biquad bass_biquad_chk #(.W(W), .GW(GW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .left_i  (left_i),
  .right_i (right_i),
  .gain_i  (gain_i),
  .valid_o (valid_o),
  .left_o  (left_o),
  .right_o (right_o),
  .filt_o  (filt_o)
);

// File: tb/bass_biquad_tb.sv
module bass_biquad_tb;
  localparam int W = 16, CW = 16, S = 1, GW = 16, GF = 12;
  localparam int TOL = 4;
  localparam int MAXV = 32767, MINV = -32768;

  logic clk = 0, rst_n = 0, valid = 0;
  logic [W-1:0] left = '0, right = '0;
  logic [5*CW-1:0] coef = '0;
  logic [GW-1:0] gain = '0;
  logic valid_o;
  logic [W-1:0] left_o, right_o, filt_o;

  int errors = 0, checks = 0;
  bit done = 0;
  real cr [5];
  real xr1, xr2, yr1, yr2;

  always #4 clk = ~clk;

  bass_biquad #(.W(W), .CW(CW), .S(S), .GW(GW), .GF(GF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .left_i(left), .right_i(right),
    .coef_i(coef), .gain_i(gain), .valid_o(valid_o), .left_o(left_o),
    .right_o(right_o), .filt_o(filt_o)
  );

  task automatic chk(string req, int act, int exp, int tol);
    int d = act - exp;
    checks++;
    if (d > tol || d < -tol) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return int'(v);
  endfunction

  function automatic int mix(int ch, int f, int g);
    longint p = (longint'(f) * longint'(g)) >>> GF;
    return clampi(longint'(ch) + p);
  endfunction

  task automatic load_set(real b0, real b1, real b2, real a1, real a2);
    real c [5];
    c = '{b0, b1, b2, a1, a2};
    for (int k = 0; k < 5; k++) begin
      int q = $rtoi(c[k] * (2.0 ** (CW - 1 - S)) + (c[k] >= 0 ? 0.5 : -0.5));
      coef[k*CW +: CW] = q[CW-1:0];
      cr[k] = q * (2.0 ** S) / (2.0 ** (CW - 1));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; valid = 0;
    repeat (2) @(negedge clk);
    chk("R1 valid_o", int'(valid_o), 0, 0);
    chk("R1 filt_o", int'($signed(filt_o)), 0, 0);
    chk("R1 left_o", int'($signed(left_o)), 0, 0);
    chk("R1 right_o", int'($signed(right_o)), 0, 0);
    rst_n = 1;
    xr1 = 0; xr2 = 0; yr1 = 0; yr2 = 0;
  endtask

  // one accepted sample; returns the observed filter output
  task automatic sample(int x, int r, int g, output int f);
    real acc, y;
    @(negedge clk);
    valid = 1; left = x[W-1:0]; right = r[W-1:0]; gain = g[GW-1:0];
    @(posedge clk); #1;
    chk("R2 valid_o high", int'(valid_o), 1, 0);
    acc = cr[0]*x + cr[1]*xr1 + cr[2]*xr2 - cr[3]*yr1 - cr[4]*yr2;
    y = acc > MAXV ? MAXV : (acc < MINV ? MINV : acc);
    f = int'($signed(filt_o));
    chk("R3/R6 filt_o vs model", f, $rtoi(y < 0 ? y - 0.5 : y + 0.5), TOL);
    chk("R8/R10 left_o mix", int'($signed(left_o)), mix(x, f, g), 0);
    chk("R9/R10 right_o mix", int'($signed(right_o)), mix(r, f, g), 0);
    xr2 = xr1; xr1 = x; yr2 = yr1; yr1 = y;
  endtask

  task automatic idle(int n);
    int pf, pl, pr;
    pf = int'($signed(filt_o)); pl = int'($signed(left_o)); pr = int'($signed(right_o));
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 0; left = $urandom; right = $urandom;
      @(posedge clk); #1;
      chk("R2 valid_o low", int'(valid_o), 0, 0);
      chk("R7 filt_o held", int'($signed(filt_o)), pf, 0);
      chk("R7 left_o held", int'($signed(left_o)), pl, 0);
      chk("R7 right_o held", int'($signed(right_o)), pr, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int f;
    void'($urandom(32'd1234));

    // R5: restored value feeds back
    load_set(1.0, 0.0, 0.0, -0.5, 0.0);
    do_reset();
    sample(1000, 0, 0, f); chk("R5 impulse y0", f, 1000, 0);
    sample(0, 0, 0, f);    chk("R5 impulse y1", f, 500, 0);
    sample(0, 0, 0, f);    chk("R5 impulse y2", f, 250, 0);

    // R4: coefficient above one
    load_set(1.5, -1.2, 0.3, -0.5, 0.1);
    do_reset();
    sample(1000, 0, 4096, f); chk("R4 gain 1.5", f, 1500, 0);
    for (int i = 0; i < 200; i++) begin
      sample($urandom_range(0, 12000) - 6000, $urandom_range(0, 40000) - 20000,
             $urandom_range(0, 12288) - 4096, f);
      if (i % 37 == 5) idle($urandom_range(1, 4));
    end

    // R6/R10: saturation in filter and mix
    load_set(1.9, 0.0, 0.0, 0.0, 0.0);
    do_reset();
    sample(30000, -30000, 32767, f);
    chk("R6 sat high", f, MAXV, 0);
    chk("R10 left clamp high", int'($signed(left_o)), MAXV, 0);
    sample(-30000, 30000, 32767, f);
    chk("R6 sat low", f, MINV, 0);
    chk("R10 left clamp low", int'($signed(left_o)), MINV, 0);

    // R3/R7: resonant set, random stimulus with idle gaps
    load_set(0.2, 0.4, 0.2, -1.0, 0.45);
    do_reset();
    for (int i = 0; i < 400; i++) begin
      sample($urandom_range(0, 16000) - 8000, $urandom_range(0, 60000) - 30000,
             $urandom_range(0, 16384) - 8192, f);
      if (i % 23 == 7) idle($urandom_range(1, 6));
    end
    sample(0, 1234, 0, f);
    chk("R8 zero gain left", int'($signed(left_o)), 0, 0);
    chk("R9 zero gain right", int'($signed(right_o)), 1234, 0);
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule